// File: doc/BRIEF.md
# USB Bus Condition Detector and Device-State Tracker

This block follows the sampled level of the USB data pair and keeps the device's standard state entirely in hardware. It times how long the line sits in single-ended zero and how long it stays idle. From those runs it recognises a bus reset and a suspend. While the device is suspended, it also spots resume signalling. Two pulses from the request handler tell it that a Set Address or a Set Configuration has completed. The tracked state is reported as a 3-bit code. A one-cycle pulse tells the interrupt unit that the code has changed, and a separate one-cycle pulse reports a resume.

Both time limits are computed at elaboration from the clock-frequency parameter, so the same block meets its timing at any clock rate. Line decoding, packet handling, frame markers and request parsing belong to neighbouring blocks.

The line state arrives as a 2-bit code: 00 = SE0, 01 = J, 10 = K, 11 = idle. The idle code is issued by the line decoder when no traffic is present.

Top module: `usb_devstate_tracker`

## Requirements
- R1: After reset, `dev_state_o` is 000 (Powered), and `state_chg_o` and `resume_o` are 0. The state encoding is as follows. Bit 2 is the suspended flag. Bits 1:0 are the base state: 00 = Powered, 01 = Default, 10 = Address, 11 = Configured.
- R2: Let T_rst = floor(2.5 us × CLK_HZ) + 1. When `line_i` = 00 (SE0) is sampled on T_rst consecutive rising edges with VBUS high, the code becomes 001 (Default) and the suspended flag clears. The update happens at the T_rst-th edge. A shorter run has no effect.
- R3: Each timer restarts from zero whenever the line leaves its condition. Each timer fires only once per unbroken run, however long the run lasts.
- R4: Let T_sus = floor(3 ms × CLK_HZ) + 1. When `line_i` = 11 (idle) is sampled on T_sus consecutive edges, bit 2 is set at the T_sus-th edge and bits 1:0 keep their value.
- R5: While suspended, a move of the line from J or idle to K or SE0 does three things at the next edge. It clears bit 2, which restores the pre-suspend state. It sets `resume_o` for one cycle. It raises `state_chg_o` for that cycle.
- R6: `set_addr_done_i` moves Default (001) to Address (010). It is ignored in every other state, including all suspended codes.
- R7: `set_cfg_done_i` moves Address (010) to Configured (011). It is ignored in every other state, including all suspended codes.
- R8: `state_chg_o` is high for exactly the one cycle in which `dev_state_o` shows a new value while VBUS is high. It stays low when an event leaves the code unchanged.
- R9: While `vbus_i` is low, the code is forced to 000, both timers are held at zero, and every other input is ignored. A VBUS fall raises no change pulse.
- R10: When several events land on the same edge, the highest-priority one wins. The order is bus reset, then suspend, then resume, then request completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_i | input | 1 | Bus power present (synchronised level) |
| line_i | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 idle |
| set_addr_done_i | input | 1 | One-cycle pulse: Set Address completed |
| set_cfg_done_i | input | 1 | One-cycle pulse: Set Configuration completed |
| dev_state_o | output | 3 | Device state code {suspended, base[1:0]} |
| state_chg_o | output | 1 | One-cycle pulse when the state code changes |
| resume_o | output | 1 | One-cycle pulse on resume detected in suspend |

## Verification
A request-completion pulse can arrive on the very edge where a line timer reaches its limit. The bench provokes this twice. In the first case, it raises Set Configuration on the final SE0 edge of a reset run that starts in Address, and the expected outcome is Default, not Configured. In the second case, it raises Set Configuration on the final idle edge of a suspend run, and the expected outcome is the suspended Address code 110. The bench also ends a suspend with SE0. It then checks that the resume pulse comes at once, and that the same unbroken SE0 run still yields a bus reset into Default.

// File: rtl/usbst_pkg.sv
package usbst_pkg;

  typedef enum logic [1:0] {
    LN_SE0  = 2'b00,
    LN_J    = 2'b01,
    LN_K    = 2'b10,
    LN_IDLE = 2'b11
  } line_e;

  localparam logic [1:0] BASE_POWERED = 2'b00;
  localparam logic [1:0] BASE_DEFAULT = 2'b01;
  localparam logic [1:0] BASE_ADDRESS = 2'b10;
  localparam logic [1:0] BASE_CONFIG  = 2'b11;

  // Cycles of SE0 needed to exceed 2.5 us: floor(hz * 2.5e-6) + 1
  function automatic int unsigned se0_run_cycles(input longint unsigned hz);
    longint unsigned whole;
    whole = (hz * 64'd5) / 64'd2_000_000;
    return int'(whole) + 1;
  endfunction

  // Cycles of idle needed to exceed 3 ms: floor(hz * 3e-3) + 1
  function automatic int unsigned idle_run_cycles(input longint unsigned hz);
    longint unsigned whole;
    whole = (hz * 64'd3) / 64'd1000;
    return int'(whole) + 1;
  endfunction

endpackage

// File: rtl/usbst_run_timer.sv
module usbst_run_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;

  assign hit = cond && (run_q == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)             run_q <= '0;
    else if (!cond)         run_q <= '0;
    else if (run_q != LIM_V) run_q <= run_q + 1'b1;
  end

  // R3: one detection per unbroken run
  a_r3_hit_once: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R3: a broken run restarts from zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (run_q == '0));

endmodule

// File: rtl/usbst_resume_det.sv
module usbst_resume_det
  import usbst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_e line,
  output logic  wake
);
  line_e prev_q;
  logic  was_quiet;
  logic  now_active;

  assign was_quiet  = (prev_q == LN_J) || (prev_q == LN_IDLE);
  assign now_active = (line == LN_K) || (line == LN_SE0);
  assign wake       = was_quiet && now_active;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= LN_IDLE;
    else        prev_q <= line;
  end

endmodule

// File: rtl/usbst_state_fsm.sv
module usbst_state_fsm
  import usbst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus,
  input  logic       rst_hit,
  input  logic       sus_hit,
  input  logic       wake,
  input  logic       set_addr,
  input  logic       set_cfg,
  output logic [2:0] state,
  output logic       chg,
  output logic       resm
);
  logic [1:0] base_q, base_d;
  logic       susp_q, susp_d;
  logic       resm_d;
  logic       chg_q, resm_q;

  always_comb begin
    base_d = base_q;
    susp_d = susp_q;
    resm_d = 1'b0;
    if (!vbus) begin
      base_d = BASE_POWERED;
      susp_d = 1'b0;
    end else if (rst_hit) begin
      base_d = BASE_DEFAULT;
      susp_d = 1'b0;
    end else if (sus_hit) begin
      susp_d = 1'b1;
    end else if (susp_q) begin
      if (wake) begin
        susp_d = 1'b0;
        resm_d = 1'b1;
      end
    end else if (set_cfg && base_q == BASE_ADDRESS) begin
      base_d = BASE_CONFIG;
    end else if (set_addr && base_q == BASE_DEFAULT) begin
      base_d = BASE_ADDRESS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= BASE_POWERED;
      susp_q <= 1'b0;
      chg_q  <= 1'b0;
      resm_q <= 1'b0;
    end else begin
      base_q <= base_d;
      susp_q <= susp_d;
      chg_q  <= vbus && ({susp_d, base_d} != {susp_q, base_q});
      resm_q <= resm_d;
    end
  end

  assign state = {susp_q, base_q};
  assign chg   = chg_q;
  assign resm  = resm_q;

  // R9: no power forces Powered without a change pulse
  a_r9_vbus_powered: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus |=> (state == 3'b000) && !chg);

  // R2: reset detection lands in Default
  a_r2_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus && rst_hit) |=> (state == 3'b001));

  // R4: suspend keeps the base bits
  a_r4_suspend_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus && sus_hit && !rst_hit) |=> state[2] && (state[1:0] == $past(state[1:0])));

  // R8: every powered change of code carries a pulse
  a_r8_chg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vbus) && (state != $past(state))) |-> chg);

  // R5: a resume pulse always means the suspended flag is clear
  a_r5_resume_awake: assert property (@(posedge clk) disable iff (!rst_n)
    resm |-> (!state[2] && $past(state[2])));

endmodule

// File: rtl/usb_devstate_tracker.sv
module usb_devstate_tracker
  import usbst_pkg::*;
#(
  parameter int unsigned CLK_HZ = 48_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus_i,
  input  logic [1:0] line_i,
  input  logic       set_addr_done_i,
  input  logic       set_cfg_done_i,
  output logic [2:0] dev_state_o,
  output logic       state_chg_o,
  output logic       resume_o
);
  localparam int unsigned SE0_CYC  = se0_run_cycles(longint'(CLK_HZ));
  localparam int unsigned IDLE_CYC = idle_run_cycles(longint'(CLK_HZ));

  line_e ln;
  logic  se0_cond, idle_cond;
  logic  rst_hit, sus_hit, wake;

  assign ln        = line_e'(line_i);
  assign se0_cond  = vbus_i && (ln == LN_SE0);
  assign idle_cond = vbus_i && (ln == LN_IDLE);

  usbst_run_timer #(.LIMIT(SE0_CYC)) u_se0_timer (
    .clk(clk), .rst_n(rst_n), .cond(se0_cond), .hit(rst_hit)
  );

  usbst_run_timer #(.LIMIT(IDLE_CYC)) u_idle_timer (
    .clk(clk), .rst_n(rst_n), .cond(idle_cond), .hit(sus_hit)
  );

  usbst_resume_det u_wake (
    .clk(clk), .rst_n(rst_n), .line(ln), .wake(wake)
  );

  usbst_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .vbus(vbus_i),
    .rst_hit(rst_hit), .sus_hit(sus_hit), .wake(wake),
    .set_addr(set_addr_done_i), .set_cfg(set_cfg_done_i),
    .state(dev_state_o), .chg(state_chg_o), .resm(resume_o)
  );

  // R10: reset outranks suspend and requests
  a_r10_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hit && vbus_i) |=> (dev_state_o == 3'b001) && !resume_o);

endmodule

// File: tb/sim_usb_devstate_tracker.sv
module sim_usb_devstate_tracker;
  localparam int unsigned HZ = 2_000_000;
  // 2.5 us is 1/400000 s, 3 ms is 3 per 1000 s
  localparam int TRST = HZ / 400_000 + 1;
  localparam int TSUS = (HZ / 1000) * 3 + 1;

  logic clk = 0, rst_n = 0, vbus = 0, sa = 0, sc = 0;
  logic [1:0] line = 2'b01;
  logic [2:0] st;
  logic chg, resm;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_devstate_tracker #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .vbus_i(vbus), .line_i(line),
    .set_addr_done_i(sa), .set_cfg_done_i(sc),
    .dev_state_o(st), .state_chg_o(chg), .resume_o(resm)
  );

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_addr();
    sa = 1; @(negedge clk); sa = 0;
  endtask

  task automatic pulse_cfg();
    sc = 1; @(negedge clk); sc = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 state", st, 3'b000);
    chk("R1 chg", {2'b0, chg}, 3'b000);
    chk("R1 resm", {2'b0, resm}, 3'b000);
  endtask

  task automatic t_no_vbus();
    line = 2'b00; wait_n(TRST + 4);
    chk("R9 se0 ignored", st, 3'b000);
    pulse_addr();
    chk("R9 addr ignored", st, 3'b000);
    line = 2'b01; vbus = 1; wait_n(2);
    chk("R9 no chg", {2'b0, chg}, 3'b000);
  endtask

  task automatic t_bus_reset();
    line = 2'b00; wait_n(TRST - 1);
    chk("R2 short run", st, 3'b000);
    line = 2'b01; wait_n(1);
    line = 2'b00; wait_n(TRST - 1);
    chk("R3 restart", st, 3'b000);
    wait_n(1);
    chk("R2 default", st, 3'b001);
    chk("R8 chg on reset", {2'b0, chg}, 3'b001);
    wait_n(1);
    chk("R8 chg one cycle", {2'b0, chg}, 3'b000);
    pulse_addr();
    chk("R6 address", st, 3'b010);
    wait_n(TRST + 4);
    chk("R3 once per run", st, 3'b010);
    line = 2'b01; wait_n(1);
  endtask

  task automatic t_config();
    pulse_cfg();
    chk("R7 configured", st, 3'b011);
    chk("R8 chg cfg", {2'b0, chg}, 3'b001);
    pulse_addr();
    chk("R6 ignored in cfg", st, 3'b011);
    chk("R8 no chg same", {2'b0, chg}, 3'b000);
  endtask

  task automatic t_suspend_resume();
    line = 2'b11; wait_n(TSUS - 1);
    chk("R4 not yet", st, 3'b011);
    wait_n(1);
    chk("R4 suspended", st, 3'b111);
    chk("R8 chg susp", {2'b0, chg}, 3'b001);
    wait_n(10);
    chk("R4 held", st, 3'b111);
    pulse_addr(); pulse_cfg();
    chk("R7 ignored in suspend", st, 3'b111);
    line = 2'b10; wait_n(1);
    chk("R5 restored", st, 3'b011);
    chk("R5 resm", {2'b0, resm}, 3'b001);
    chk("R5 chg", {2'b0, chg}, 3'b001);
    wait_n(1);
    chk("R5 resm one cycle", {2'b0, resm}, 3'b000);
    line = 2'b01; wait_n(1);
  endtask

  task automatic t_reset_vs_cfg();
    line = 2'b00; wait_n(TRST);
    chk("R2 from cfg", st, 3'b001);
    line = 2'b01; wait_n(1);
    pulse_addr();
    line = 2'b00; wait_n(TRST - 1);
    pulse_cfg();
    chk("R10 reset beats cfg", st, 3'b001);
    line = 2'b01; wait_n(1);
  endtask

  task automatic t_suspend_vs_cfg();
    pulse_addr();
    chk("R6 addr again", st, 3'b010);
    line = 2'b11; wait_n(TSUS - 1);
    pulse_cfg();
    chk("R10 suspend beats cfg", st, 3'b110);
    line = 2'b00; wait_n(1);
    chk("R5 se0 resume", st, 3'b010);
    chk("R5 se0 resm", {2'b0, resm}, 3'b001);
    wait_n(TRST - 1);
    chk("R2 reset after resume", st, 3'b001);
    line = 2'b01; wait_n(1);
  endtask

  task automatic t_vbus_drop();
    pulse_addr(); pulse_cfg();
    chk("R7 cfg before drop", st, 3'b011);
    vbus = 0; wait_n(1);
    chk("R9 powered", st, 3'b000);
    chk("R9 no chg on drop", {2'b0, chg}, 3'b000);
    vbus = 1; wait_n(1);
    pulse_addr();
    chk("R6 ignored in powered", st, 3'b000);
    pulse_cfg();
    chk("R7 ignored in powered", st, 3'b000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    t_reset_state();
    t_no_vbus();
    t_bus_reset();
    t_config();
    t_suspend_resume();
    t_reset_vs_cfg();
    t_suspend_vs_cfg();
    t_vbus_drop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule